// File: doc/BRIEF.md
# Opcode-Selected Arithmetic Logic Unit with Status Flags

This block is a purely combinational arithmetic logic unit. It takes two operands and a 4-bit operation code, and in the same cycle it returns a result word and four status flags: zero, carry, overflow and negative. It is meant to sit inside a datapath. A sequencer presents operands and an opcode, then samples the result and flags at its own clock edge.

Inside, one ripple-carry adder built from full-adder cells serves addition, subtraction, increment, decrement and the signed less-than compare. For subtraction an inversion control flips the second operand and forces the carry-in high. A bitwise unit handles AND, OR, XOR and complement. A one-place shifter handles left and logical-right moves, and sends the bit it drops to the carry flag. An opcode-driven multiplexer picks which unit's result and carry/overflow pair reaches the outputs. Zero and negative are always derived from the selected result. The operand width is a parameter; the opcode map is fixed.

Top module: `opsel_alu`

## Requirements
- R1: Opcode 4'b0000 (add) gives result = (A + B) mod 256. C is the carry out of bit 7. V is 1 exactly when A and B have equal sign bits and the result sign differs from them (0x7F + 0x01 gives 0x80, V=1, N=1, C=0).
- R2: Opcode 4'b0001 (subtract) gives result = (A − B) mod 256. C is a borrow, equal to 1 exactly when A < B as unsigned values. V is 1 exactly when A and B have different sign bits and the result sign differs from A's (0x10 − 0x30 gives 0xE0, C=1, N=1, V=0).
- R3: Opcodes 4'b0010, 4'b0011, 4'b0100 and 4'b0101 give A AND B, A OR B, A XOR B and NOT A respectively, with C=0 and V=0 (0xAB AND 0x0F gives 0x0B; 0x55 XOR 0x55 gives 0x00).
- R4: Opcode 4'b0110 gives A shifted left one place with 0 entering bit 0. C = A[7] and V=0 (0x81 gives 0x02, C=1).
- R5: Opcode 4'b0111 gives A shifted right one place with 0 entering bit 7. C = A[0] and V=0.
- R6: Opcode 4'b1000 gives 0x01 when A < B as signed two's-complement values, otherwise 0x00, with C=0 and V=0.
- R7: Opcode 4'b1001 gives (A + 1) mod 256, with C and V following the add rule against an operand of 1. Opcode 4'b1010 gives (A − 1) mod 256, with C and V following the subtract rule against an operand of 1 (so C=1 only for A=0x00 and V=1 only for A=0x80).
- R8: Opcode 4'b1011 passes A to the result unchanged, with C=0 and V=0.
- R9: Opcodes 4'b1100 to 4'b1111 give result 0x00 with C=0 and V=0, and therefore Z=1 and N=0.
- R10: For every opcode, Z is 1 exactly when the result is 0x00, and N equals result bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 4 | Operation code |
| result_o | output | WIDTH | Selected result word |
| zero_o | output | 1 | Result is all zeros |
| carry_o | output | 1 | Carry out, borrow, or shifted-out bit |
| ovf_o | output | 1 | Signed overflow |
| neg_o | output | 1 | Most significant bit of the result |

## Verification
All sixteen opcode values are swept against every one of the 65,536 operand pairs. The sweep therefore reaches the sign boundaries 0x7F/0x80 and the extremes 0x00/0xFF from both sides. These boundaries separate a correct overflow rule from one that looks only at the carry, and a borrow-style carry from a raw adder carry-out. Signed less-than is told apart from an unsigned compare by the pairs where the operands' sign bits differ. The four unused opcodes are swept too, so any leakage from an active unit into the default result shows up. A few hand-picked vectors with known answers come first, so the bench's own expected-value model is cross-checked against fixed values.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOTA = 4'd5,
        OP_SHL  = 4'd6,
        OP_SHR  = 4'd7,
        OP_SLT  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_PASS = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        LF_AND  = 2'd0,
        LF_OR   = 2'd1,
        LF_XOR  = 2'd2,
        LF_NOTA = 2'd3
    } logic_fn_e;

    typedef enum logic {
        SH_LEFT  = 1'b0,
        SH_RIGHT = 1'b1
    } shift_dir_e;

endpackage

// File: rtl/opsel_alu_fa.sv
module opsel_alu_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    logic half_d;

    always_comb begin
        half_d = x_i ^ y_i;
        s_o    = half_d ^ c_i;
        c_o    = (x_i & y_i) | (c_i & half_d);
    end

endmodule

// File: rtl/opsel_alu_adder.sv
module opsel_alu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             inv_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] y_eff_d;
    logic [WIDTH:0]   chain_d;

    always_comb begin
        y_eff_d    = y_i ^ {WIDTH{inv_i}};
        chain_d[0] = cin_i;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        opsel_alu_fa u_fa (
            .x_i (x_i[g]),
            .y_i (y_eff_d[g]),
            .c_i (chain_d[g]),
            .s_o (sum_o[g]),
            .c_o (chain_d[g+1])
        );
    end

    always_comb begin
        cout_o = chain_d[WIDTH];
        ovf_o  = (x_i[MSB] == y_eff_d[MSB]) && (sum_o[MSB] != x_i[MSB]);
    end

endmodule

// File: rtl/opsel_alu_logic.sv
module opsel_alu_logic #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]       a_i,
    input  logic [WIDTH-1:0]       b_i,
    input  opsel_alu_pkg::logic_fn_e fn_i,
    output logic [WIDTH-1:0]       y_o
);

    import opsel_alu_pkg::*;

    always_comb begin
        unique case (fn_i)
            LF_AND:  y_o = a_i & b_i;
            LF_OR:   y_o = a_i | b_i;
            LF_XOR:  y_o = a_i ^ b_i;
            LF_NOTA: y_o = ~a_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/opsel_alu_shift.sv
module opsel_alu_shift #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]          a_i,
    input  opsel_alu_pkg::shift_dir_e dir_i,
    output logic [WIDTH-1:0]          y_o,
    output logic                      out_bit_o
);

    import opsel_alu_pkg::*;

    localparam int MSB = WIDTH - 1;

    always_comb begin
        if (dir_i == SH_LEFT) begin
            y_o       = {a_i[MSB-1:0], 1'b0};
            out_bit_o = a_i[MSB];
        end else begin
            y_o       = {1'b0, a_i[MSB:1]};
            out_bit_o = a_i[0];
        end
    end

endmodule

// File: rtl/opsel_alu.sv
module opsel_alu #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]              a_i,
    input  logic [WIDTH-1:0]              b_i,
    input  logic [opsel_alu_pkg::OPW-1:0] op_i,
    output logic [WIDTH-1:0]              result_o,
    output logic                          zero_o,
    output logic                          carry_o,
    output logic                          ovf_o,
    output logic                          neg_o
);

    import opsel_alu_pkg::*;

    localparam int MSB = WIDTH - 1;
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] val;
        logic             c;
        logic             v;
    } alu_out_t;

    logic [WIDTH-1:0] add_y_d;
    logic             add_inv_d;
    logic             add_cin_d;
    logic [WIDTH-1:0] add_sum_d;
    logic             add_cout_d;
    logic             add_ovf_d;
    logic             add_c_d;
    logic             less_d;
    logic_fn_e        lfn_d;
    logic [WIDTH-1:0] log_y_d;
    shift_dir_e       sdir_d;
    logic [WIDTH-1:0] sh_y_d;
    logic             sh_out_d;
    alu_out_t         res_d;

    // Adder operand steering: subtract-style ops invert and carry in a 1.
    always_comb begin
        add_y_d   = b_i;
        add_inv_d = 1'b0;
        add_cin_d = 1'b0;
        case (op_i)
            OP_SUB, OP_SLT: begin
                add_inv_d = 1'b1;
                add_cin_d = 1'b1;
            end
            OP_INC: begin
                add_y_d   = '0;
                add_cin_d = 1'b1;
            end
            OP_DEC: begin
                add_y_d   = ONE;
                add_inv_d = 1'b1;
                add_cin_d = 1'b1;
            end
            default: ;
        endcase
    end

    opsel_alu_adder #(.WIDTH(WIDTH)) u_adder (
        .x_i    (a_i),
        .y_i    (add_y_d),
        .inv_i  (add_inv_d),
        .cin_i  (add_cin_d),
        .sum_o  (add_sum_d),
        .cout_o (add_cout_d),
        .ovf_o  (add_ovf_d)
    );

    always_comb begin
        lfn_d = LF_AND;
        case (op_i)
            OP_OR:   lfn_d = LF_OR;
            OP_XOR:  lfn_d = LF_XOR;
            OP_NOTA: lfn_d = LF_NOTA;
            default: lfn_d = LF_AND;
        endcase
        sdir_d = (op_i == OP_SHR) ? SH_RIGHT : SH_LEFT;
    end

    opsel_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a_i  (a_i),
        .b_i  (b_i),
        .fn_i (lfn_d),
        .y_o  (log_y_d)
    );

    opsel_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .a_i       (a_i),
        .dir_i     (sdir_d),
        .y_o       (sh_y_d),
        .out_bit_o (sh_out_d)
    );

    // Borrow convention on the inverting path; signed less-than from N ^ V.
    always_comb begin
        add_c_d = add_inv_d ? ~add_cout_d : add_cout_d;
        less_d  = add_sum_d[MSB] ^ add_ovf_d;
    end

    // Result multiplexer.
    always_comb begin
        res_d = '0;
        case (op_i)
            OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
                res_d.val = add_sum_d;
                res_d.c   = add_c_d;
                res_d.v   = add_ovf_d;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOTA: begin
                res_d.val = log_y_d;
            end
            OP_SHL, OP_SHR: begin
                res_d.val = sh_y_d;
                res_d.c   = sh_out_d;
            end
            OP_SLT: begin
                res_d.val = less_d ? ONE : '0;
            end
            OP_PASS: begin
                res_d.val = a_i;
            end
            default: res_d = '0;
        endcase
    end

    always_comb begin
        result_o = res_d.val;
        carry_o  = res_d.c;
        ovf_o    = res_d.v;
        zero_o   = ~|res_d.val;
        neg_o    = res_d.val[MSB];
    end

endmodule

// File: rtl/opsel_alu_chk.sv
module opsel_alu_chk #(
    parameter int W = 8
) (
    input logic [W-1:0]                  a_i,
    input logic [W-1:0]                  b_i,
    input logic [opsel_alu_pkg::OPW-1:0] op_i,
    input logic [W-1:0]                  result_o,
    input logic                          zero_o,
    input logic                          carry_o,
    input logic                          ovf_o,
    input logic                          neg_o
);

    import opsel_alu_pkg::*;

    logic [W:0]   wide_sum;
    logic [W-1:0] slt_val;

    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, b_i};
        slt_val  = ($signed(a_i) < $signed(b_i)) ? W'(1) : W'(0);
    end

    always_comb begin
        if (!$isunknown({a_i, b_i, op_i, result_o, zero_o, carry_o, ovf_o, neg_o})) begin
            if (op_i == OP_ADD) begin
                a_r1_add_sum: assert ({carry_o, result_o} == wide_sum)
                    else $error("R1 add mismatch");
            end
            if (op_i == OP_SUB) begin
                a_r2_sub_borrow: assert (result_o == W'(a_i - b_i) && carry_o == (a_i < b_i))
                    else $error("R2 subtract mismatch");
            end
            if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_NOTA) begin
                a_r3_logic_no_cv: assert (!carry_o && !ovf_o)
                    else $error("R3 logic flags");
            end
            if (op_i == OP_SHL) begin
                a_r4_shl_carry: assert (carry_o == a_i[W-1] && !ovf_o && !result_o[0])
                    else $error("R4 shift left");
            end
            if (op_i == OP_SHR) begin
                a_r5_shr_carry: assert (carry_o == a_i[0] && !ovf_o && !result_o[W-1])
                    else $error("R5 shift right");
            end
            if (op_i == OP_SLT) begin
                a_r6_slt_signed: assert (result_o == slt_val && !carry_o && !ovf_o)
                    else $error("R6 signed compare");
            end
            if (op_i == OP_PASS) begin
                a_r8_pass: assert (result_o == a_i && !carry_o && !ovf_o)
                    else $error("R8 pass");
            end
            if (op_i >= 4'd12) begin
                a_r9_unused_op: assert (result_o == '0 && !carry_o && !ovf_o)
                    else $error("R9 unused opcode");
            end
            a_r10_zero_flag: assert (zero_o == (result_o == '0))
                else $error("R10 zero flag");
            a_r10_neg_flag: assert (neg_o == result_o[W-1])
                else $error("R10 negative flag");
        end
    end

endmodule

bind opsel_alu opsel_alu_chk #(.W(WIDTH)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_i),
    .result_o (result_o),
    .zero_o   (zero_o),
    .carry_o  (carry_o),
    .ovf_o    (ovf_o),
    .neg_o    (neg_o)
);

// File: tb/opsel_alu_tb.sv
`timescale 1ns/1ps
module opsel_alu_tb;

    logic       clk;
    logic [7:0] a, b;
    logic [3:0] op;
    logic [7:0] res;
    logic       z, c, v, n;
    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;

    initial clk = 1'b0;
    always #5 clk = ~clk;

    opsel_alu #(.WIDTH(8)) u_dut (
        .a_i      (a),
        .b_i      (b),
        .op_i     (op),
        .result_o (res),
        .zero_o   (z),
        .carry_o  (c),
        .ovf_o    (v),
        .neg_o    (n)
    );

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0:                      return "R1";
            4'd1:                      return "R2";
            4'd2, 4'd3, 4'd4, 4'd5:    return "R3";
            4'd6:                      return "R4";
            4'd7:                      return "R5";
            4'd8:                      return "R6";
            4'd9, 4'd10:               return "R7";
            4'd11:                     return "R8";
            default:                   return "R9";
        endcase
    endfunction

    // Arithmetic reference model, written from the requirements.
    task automatic model(input logic [7:0] ea, input logic [7:0] eb, input logic [3:0] eo,
                         output logic [7:0] er, output logic ec, output logic ev);
        logic [8:0] s;
        er = 8'h00; ec = 1'b0; ev = 1'b0;
        case (eo)
            4'd0: begin
                s = {1'b0, ea} + {1'b0, eb};
                er = s[7:0]; ec = s[8];
                ev = (ea[7] == eb[7]) && (er[7] != ea[7]);
            end
            4'd1: begin
                er = ea - eb; ec = (ea < eb);
                ev = (ea[7] != eb[7]) && (er[7] != ea[7]);
            end
            4'd2:  er = ea & eb;
            4'd3:  er = ea | eb;
            4'd4:  er = ea ^ eb;
            4'd5:  er = ~ea;
            4'd6:  begin er = {ea[6:0], 1'b0}; ec = ea[7]; end
            4'd7:  begin er = {1'b0, ea[7:1]}; ec = ea[0]; end
            4'd8:  er = ($signed(ea) < $signed(eb)) ? 8'h01 : 8'h00;
            4'd9:  begin er = ea + 8'h01; ec = (ea == 8'hFF); ev = (ea == 8'h7F); end
            4'd10: begin er = ea - 8'h01; ec = (ea == 8'h00); ev = (ea == 8'h80); end
            4'd11: er = ea;
            default: ;
        endcase
    endtask

    task automatic apply_and_check(input logic [7:0] ta, input logic [7:0] tb_, input logic [3:0] to);
        logic [7:0] er;
        logic       ec, ev;
        a = ta; b = tb_; op = to;
        #0.5;
        model(ta, tb_, to, er, ec, ev);
        checks++;
        if (res !== er || c !== ec || v !== ev) begin
            errors++;
            $display("FAIL %s a=%h b=%h op=%0d actual res=%h c=%b v=%b expected res=%h c=%b v=%b",
                     tag_of(to), ta, tb_, to, res, c, v, er, ec, ev);
        end
        checks++;
        if (z !== (er == 8'h00) || n !== er[7]) begin
            errors++;
            $display("FAIL R10 a=%h b=%h op=%0d actual z=%b n=%b expected z=%b n=%b",
                     ta, tb_, to, z, n, (er == 8'h00), er[7]);
        end
        #0.5;
    endtask

    task automatic fixed_vec(input logic [7:0] ta, input logic [7:0] tb_, input logic [3:0] to,
                             input logic [7:0] xr, input logic xc, input logic xv,
                             input logic xz, input logic xn, input string tg);
        a = ta; b = tb_; op = to;
        #0.5;
        checks++;
        if (res !== xr || c !== xc || v !== xv || z !== xz || n !== xn) begin
            errors++;
            $display("FAIL %s fixed vector actual res=%h c=%b v=%b z=%b n=%b expected res=%h c=%b v=%b z=%b n=%b",
                     tg, res, c, v, z, n, xr, xc, xv, xz, xn);
        end
        #0.5;
    endtask

    initial begin
        a = 8'h00; b = 8'h00; op = 4'd0;
        @(posedge clk);
        #2;
        // Reset-like idle state: zero operands through add give zero with Z set (R1, R10).
        checks++;
        if (res !== 8'h00 || z !== 1'b1 || c !== 1'b0 || v !== 1'b0 || n !== 1'b0) begin
            errors++;
            $display("FAIL R10 idle state actual res=%h z=%b expected res=00 z=1", res, z);
        end
        fixed_vec(8'h25, 8'h1A, 4'd0,  8'h3F, 0, 0, 0, 0, "R1");
        fixed_vec(8'h7F, 8'h01, 4'd0,  8'h80, 0, 1, 0, 1, "R1");
        fixed_vec(8'h30, 8'h10, 4'd1,  8'h20, 0, 0, 0, 0, "R2");
        fixed_vec(8'h10, 8'h30, 4'd1,  8'hE0, 1, 0, 0, 1, "R2");
        fixed_vec(8'hAB, 8'h0F, 4'd2,  8'h0B, 0, 0, 0, 0, "R3");
        fixed_vec(8'h55, 8'h55, 4'd4,  8'h00, 0, 0, 1, 0, "R3");
        fixed_vec(8'h81, 8'h00, 4'd6,  8'h02, 1, 0, 0, 0, "R4");
        fixed_vec(8'h81, 8'h00, 4'd7,  8'h40, 1, 0, 0, 0, "R5");
        fixed_vec(8'h80, 8'h7F, 4'd8,  8'h01, 0, 0, 0, 0, "R6");
        fixed_vec(8'h7F, 8'h80, 4'd8,  8'h00, 0, 0, 1, 0, "R6");
        fixed_vec(8'hFF, 8'h00, 4'd9,  8'h00, 1, 0, 1, 0, "R7");
        fixed_vec(8'h80, 8'h00, 4'd10, 8'h7F, 0, 1, 0, 0, "R7");
        fixed_vec(8'hC3, 8'h11, 4'd11, 8'hC3, 0, 0, 0, 1, "R8");
        fixed_vec(8'hFF, 8'hFF, 4'd13, 8'h00, 0, 0, 1, 0, "R9");
        // Exhaustive sweep of every opcode and operand pair.
        for (int o = 0; o < 16; o++) begin
            for (int i = 0; i < 256; i++) begin
                for (int j = 0; j < 256; j++) begin
                    apply_and_check(8'(i), 8'(j), 4'(o));
                end
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule